// File: doc/BRIEF.md
# Tile Row Integer-to-Float Converter

This block reads one row of a small matrix tile and returns a 512-bit vector of sixteen IEEE single-precision lanes. Each lane is a 32-bit two's-complement integer from the row, converted with round-to-nearest-even. A 32-bit selector picks the row and a 64-byte window (chunk) within that row. Lanes that fall beyond the tile's configured width in bytes (colsb) are forced to zero.

The tile arrives as a flat bus of sixteen rows of 64 bytes, row 0 in the low bits. A one-cycle start pulse samples the selector, the width and the tile. The converted vector is registered and appears on the next cycle, together with a one-cycle valid strobe. Between conversions the vector output holds its last value. The conversion never depends on a rounding-mode control and raises no exception flags.

Top module: `tile_row_cvt`

## Requirements
- R1: While rst_ni is low and after its release, until the first start, valid_o is 0 and vec_o is all zero.
- R2: valid_o is 1 in exactly the cycle after a cycle with start_i high, and 0 otherwise.
- R3: The row index is sel_i[15:0]. Row r occupies tile_i[r*512 +: 512], and its dword d is at bits [d*32 +: 32] of that row. A row index of 16 or more yields an all-zero vector.
- R4: The chunk number is sel_i[31:16]. Lane i (vec_o[i*32 +: 32]) takes row dword chunk*16 + i. A dword position past the 16 dwords of the row gives a zero lane.
- R5: Lane i is zero when i + chunk*16 >= colsb_i/4, using integer division, so the two low bits of colsb_i have no effect.
- R6: A non-masked lane holds the signed integer converted to binary32 (sign bit 31, biased exponent bits 30:23 with bias 127, fraction bits 22:0). Any magnitude up to 2^24 is exact, and 0 gives 0x00000000.
- R7: Magnitudes above 2^24 round to nearest with ties to even. For example, 16777217 gives 0x4B800000, 16777219 gives 0x4B800002, and -2^31 gives 0xCF000000.
- R8: In a cycle after a cycle without start_i, vec_o equals its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts one conversion |
| sel_i | input | 32 | Selector: chunk in [31:16], row in [15:0] |
| colsb_i | input | 16 | Configured bytes per tile row |
| tile_i | input | 8192 | Tile contents, 16 rows of 512 bits |
| vec_o | output | 512 | Sixteen binary32 lanes |
| valid_o | output | 1 | High one cycle after start_i |

## Verification
The whole result has one register stage. The vector and the valid strobe are due in the cycle right after the start cycle. The bench raises start on a falling edge and drops it on the next falling edge, then compares every lane there, half a cycle after the capturing edge. It checks again one falling edge later that valid has dropped and the vector is unchanged. Rows, chunks and widths are swept nearly exhaustively, and every expected lane comes from an arithmetic quotient-and-remainder rounding model in the bench.

// File: rtl/tile_row_cvt_pkg.sv
package tile_row_cvt_pkg;
  localparam int unsigned DW        = 32;
  localparam int unsigned VEC_BYTES = 64;
  localparam int unsigned LANES     = VEC_BYTES / 4;
  localparam int unsigned VEC_W     = VEC_BYTES * 8;
  localparam int unsigned F32_BIAS  = 127;
  localparam int unsigned F32_MANT  = 23;

  typedef logic [DW-1:0] dword_t;
endpackage

// File: rtl/tile_i2f_lane.sv
module tile_i2f_lane
  import tile_row_cvt_pkg::*;
(
  input  dword_t int_i,
  output dword_t flt_o
);
  logic        sgn;
  dword_t      mag, norm;
  logic [4:0]  msb;
  logic        guard, sticky, rup;
  logic [24:0] sum;
  logic [7:0]  bexp;

  always_comb begin
    sgn = int_i[31];
    mag = sgn ? (~int_i + 32'd1) : int_i;
    msb = '0;
    for (int b = 0; b < 32; b++) begin
      if (mag[b]) msb = 5'(b);
    end
    // leading one moved to bit 31; bits below 8 are rounding bits
    norm   = mag << (5'd31 - msb);
    guard  = norm[7];
    sticky = |norm[6:0];
    rup    = guard & (sticky | norm[8]);
    sum    = {1'b0, norm[31:8]} + {24'd0, rup};
    bexp   = 8'(F32_BIAS) + {3'd0, msb} + {7'd0, sum[24]};
    if (mag == '0) flt_o = '0;
    else           flt_o = {sgn, bexp, sum[24] ? 23'd0 : sum[22:0]};
  end
endmodule

// File: rtl/tile_row_lanes.sv
module tile_row_lanes
  import tile_row_cvt_pkg::*;
#(
  parameter int unsigned ROW_BYTES = 64,
  localparam int unsigned ROW_W    = ROW_BYTES * 8,
  localparam int unsigned ROW_DW   = ROW_BYTES / 4,
  localparam int unsigned DW_AW    = (ROW_DW > 1) ? $clog2(ROW_DW) : 1
) (
  input  logic [ROW_W-1:0]  row_i,
  input  logic              row_ok_i,
  input  logic [15:0]       chunk_i,
  input  logic [15:0]       colsb_i,
  output dword_t            lane_o [LANES]
);
  logic [31:0] cfg_dw;
  assign cfg_dw = {18'd0, colsb_i[15:2]};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [31:0]      pos;
    logic             keep;
    logic [DW_AW-1:0] idx;
    assign pos  = {16'd0, chunk_i} * 32'(LANES) + 32'(i);
    assign keep = row_ok_i && (pos < cfg_dw) && (pos < 32'(ROW_DW));
    assign idx  = pos[DW_AW-1:0];
    assign lane_o[i] = keep ? row_i[idx*DW +: DW] : '0;
  end
endmodule

// File: rtl/tile_row_cvt.sv
module tile_row_cvt
  import tile_row_cvt_pkg::*;
#(
  parameter int unsigned ROWS      = 16,
  parameter int unsigned ROW_BYTES = 64,
  localparam int unsigned ROW_W    = ROW_BYTES * 8,
  localparam int unsigned TILE_W   = ROWS * ROW_W,
  localparam int unsigned ROW_AW   = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [31:0]       sel_i,
  input  logic [15:0]       colsb_i,
  input  logic [TILE_W-1:0] tile_i,
  output logic [VEC_W-1:0]  vec_o,
  output logic              valid_o
);
  logic              row_ok;
  logic [ROW_AW-1:0] row_idx;
  logic [ROW_W-1:0]  row_data;
  dword_t            lane_int [LANES];
  logic [VEC_W-1:0]  vec_d;

  assign row_ok   = {16'd0, sel_i[15:0]} < 32'(ROWS);
  assign row_idx  = sel_i[ROW_AW-1:0];
  assign row_data = tile_i[row_idx*ROW_W +: ROW_W];

  tile_row_lanes #(.ROW_BYTES(ROW_BYTES)) u_lanes (
    .row_i    (row_data),
    .row_ok_i (row_ok),
    .chunk_i  (sel_i[31:16]),
    .colsb_i  (colsb_i),
    .lane_o   (lane_int)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_cvt
    dword_t flt;
    tile_i2f_lane u_i2f (.int_i(lane_int[i]), .flt_o(flt));
    assign vec_d[i*DW +: DW] = flt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= start_i;
      if (start_i) vec_o <= vec_d;
    end
  end
endmodule

// File: rtl/tile_row_cvt_chk.sv
module tile_row_cvt_chk
  import tile_row_cvt_pkg::*;
#(
  parameter int unsigned ROWS = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [31:0]      sel_i,
  input logic [15:0]      colsb_i,
  input logic [VEC_W-1:0] vec_o,
  input logic             valid_o
);
  assert_valid_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o);
  assert_valid_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !valid_o);
  assert_bad_row_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && ({16'd0, sel_i[15:0]} >= 32'(ROWS))) |=> (vec_o == '0));
  assert_narrow_cfg_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (colsb_i < 16'd4)) |=> (vec_o == '0));
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(vec_o));
endmodule

bind tile_row_cvt tile_row_cvt_chk #(.ROWS(ROWS)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .sel_i   (sel_i),
  .colsb_i (colsb_i),
  .vec_o   (vec_o),
  .valid_o (valid_o)
);

// File: tb/test_tile_row_cvt.sv
`timescale 1ns/1ps
module test_tile_row_cvt;
  localparam int ROWS = 16;
  localparam int RDW  = 16;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [31:0]  sel_i = '0;
  logic [15:0]  colsb_i = '0;
  logic [8191:0] tile_i;
  logic [511:0] vec_o;
  logic         valid_o;

  logic [31:0] mem [ROWS][RDW];
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  always_comb begin
    for (int r = 0; r < ROWS; r++)
      for (int d = 0; d < RDW; d++)
        tile_i[(r*RDW+d)*32 +: 32] = mem[r][d];
  end

  tile_row_cvt i_tile_row_cvt (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .sel_i(sel_i),
    .colsb_i(colsb_i), .tile_i(tile_i), .vec_o(vec_o), .valid_o(valid_o)
  );

  function automatic logic [31:0] ref_cvt(input logic [31:0] x);
    longint m, q, rem, half;
    int e, sh;
    logic s;
    if (x == 0) return 32'd0;
    s = x[31];
    m = s ? -longint'($signed(x)) : longint'(x);
    e = 0;
    while ((m >> (e + 1)) != 0) e++;
    if (e <= 23) begin
      q = m << (23 - e);
    end else begin
      sh = e - 23;
      q = m >> sh;
      rem = m - (q << sh);
      half = longint'(1) << (sh - 1);
      if (rem > half || (rem == half && q[0])) q++;
      if (q == (longint'(1) << 24)) begin
        q = longint'(1) << 23;
        e++;
      end
    end
    return {s, 8'(e + 127), 23'(q)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input int lane);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s lane %0d: actual %h expected %h", req, lane, act, exp);
    end
  endtask

  task automatic run(input int row, input int chunk, input int cb, input string req);
    logic [511:0] prev;
    logic [31:0] exp;
    int pos, bad;
    @(negedge clk);
    sel_i = {16'(chunk), 16'(row)};
    colsb_i = 16'(cb);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R2 valid", {31'd0, valid_o}, 32'd1, -1);
    bad = -1;
    for (int i = 0; i < 16; i++) begin
      pos = chunk * 16 + i;
      if (row >= ROWS || pos >= cb / 4 || pos >= RDW) exp = 32'd0;
      else exp = ref_cvt(mem[row][pos]);
      if (vec_o[i*32 +: 32] !== exp && bad < 0) begin
        bad = i;
        check(req, vec_o[i*32 +: 32], exp, i);
      end
    end
    if (bad < 0) check(req, 32'd0, 32'd0, 0);
    prev = vec_o;
    sel_i = ~sel_i;
    colsb_i = 16'd64;
    @(negedge clk);
    check("R2 single pulse", {31'd0, valid_o}, 32'd0, -1);
    check("R8 hold", {31'd0, vec_o === prev}, 32'd1, -1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] sp [16];
    sp = '{32'd0, 32'h8000_0000, 32'h7FFF_FFFF, 32'd16777216, 32'd16777217,
           32'd16777219, 32'd16777218, -32'd16777217, -32'd16777219, 32'd1,
           -32'd1, 32'd33554435, 32'd33554434, 32'd8388607, -32'd123456789, 32'h4000_0001};
    for (int d = 0; d < RDW; d++) mem[0][d] = sp[d];
    for (int r = 1; r < ROWS; r++)
      for (int d = 0; d < RDW; d++)
        mem[r][d] = $urandom() >> ((r * 2 + d) % 31);
    #1;
    repeat (3) @(negedge clk);
    check("R1 reset valid", {31'd0, valid_o}, 32'd0, -1);
    check("R1 reset vec", {31'd0, vec_o == '0}, 32'd1, -1);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 idle valid", {31'd0, valid_o}, 32'd0, -1);
    check("R1 idle vec", {31'd0, vec_o == '0}, 32'd1, -1);
    // R7 special values in row 0, then R6 across all rows
    run(0, 0, 64, "R7 rounding");
    for (int r = 0; r < ROWS + 2; r++)
      for (int c = 0; c < 3; c++)
        for (int cb = 0; cb <= 68; cb += 4)
          run(r, c, cb, r >= ROWS ? "R3 row range" : (c > 0 ? "R4 chunk" : "R6 convert"));
    // R5 low colsb bits ignored
    for (int cb = 0; cb < 70; cb++) run(cb % ROWS, 0, cb, "R5 mask");
    run(3, 16'hFFFF, 16'hFFFF, "R4 far chunk");
    run(16'hFFFF, 0, 64, "R3 large row");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule